// File: doc/BRIEF.md
# Backup-Domain Control Register

This block is a single memory-mapped control word that lives in a battery-backed power domain. It holds the controls for a low-speed external oscillator (enable and bypass), a two-bit clock-source select and an enable for a real-time clock, and a software reset for the whole backup domain. It also carries a read-only flag that shows when the oscillator is stable. The register sits on a simple peripheral bus with byte enables and a ready handshake, and it inserts wait states when accesses follow each other with no gap.

Writes to the oscillator and real-time-clock fields only take effect while the external domain-write-permit input is high. These fields ignore system resets and clear only on a backup-domain reset. That reset comes either from the dedicated external input or from the software reset bit. The block drives the combined reset to the rest of the domain. The oscillator status input is brought into the bus clock domain through a synchroniser.

Top module: `bkdom_ctrl_reg`

## Requirements
- R1: While `bkd_rst_n` is low, and after it is released, every writable field reads 0 and `osc_en_o`, `osc_byp_o`, `rtc_sel_o` and `rtc_en_o` are 0.
- R2: At address 0x20 the word has this layout: bit 0 is the oscillator enable, bit 2 is the oscillator bypass, bits 9:8 are the clock-source select, bit 15 is the real-time-clock enable and bit 16 is the software domain reset. A write is read back at these positions, and the field outputs follow it from the cycle after the write completes.
- R3: Bits 31:17, 14:10 and 7:3 always read 0, and writing ones to them changes nothing.
- R4: While `dom_wr_permit` is 0, a write leaves the oscillator enable, bypass, source select and real-time-clock enable unchanged.
- R5: Asserting `sys_rst_n` low does not change any field held in the backup domain.
- R6: `bkd_rst_o` is high whenever bit 16 is 1 or `bkd_rst_n` is low. Bit 16 can be written whether or not `dom_wr_permit` is high.
- R7: While bit 16 is 1, the four protected fields are 0 from the next cycle on, and writes to them have no effect.
- R8: Bit 1 reads `osc_rdy_i` as sampled two clock edges earlier. It is 0 after a system reset, and writes do not affect it.
- R9: An access presented when no access completed in the previous cycle has `acc_ready` high in its first cycle.
- R10: An access presented in the cycle right after another one completed keeps `acc_ready` low for exactly 2 cycles and completes in the third.
- R11: Byte enables act per lane. `acc_be[0]` covers bits 7:0, `acc_be[1]` covers bits 15:8 and `acc_be[2]` covers bits 23:16. A lane whose enable is 0 keeps its fields.
- R12: An access to any address other than 0x20 writes nothing and reads 0, with the same ready timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | System reset, active low. Resets only the bus and synchroniser logic |
| bkd_rst_n | input | 1 | External backup-domain reset, active low |
| acc_en | input | 1 | Access request, held high until `acc_ready` |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (8) | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_be | input | 4 | Byte-lane enables for writes |
| acc_ready | output | 1 | Access completes in the cycle where this is high |
| acc_rdata | output | 32 | Read data, valid while a read completes |
| dom_wr_permit | input | 1 | Allows writes to the protected domain fields |
| osc_rdy_i | input | 1 | Asynchronous oscillator-stable status |
| osc_en_o | output | 1 | Oscillator enable |
| osc_byp_o | output | 1 | Oscillator bypass |
| rtc_sel_o | output | 2 | Real-time-clock source select |
| rtc_en_o | output | 1 | Real-time-clock enable |
| bkd_rst_o | output | 1 | Combined backup-domain reset, active high |

## Verification
A wrong internal state shows up at the ports within one cycle. A corrupted field value appears on the field outputs in the very next cycle, while the matching read word is only seen when software reads it back. A wrong wait-state count or a stuck completion flag shows up as `acc_ready` high or low in the wrong cycle of a back-to-back pair. A synchroniser of the wrong depth shifts the ready flag by one read-visible cycle. The reference model is compared on every clock, so each of these is caught in the first cycle where it differs.

// File: rtl/bkdom_pkg.sv
package bkdom_pkg;

   localparam int DATA_W      = 32;
   localparam int POS_OSC_EN  = 0;
   localparam int POS_RDY     = 1;
   localparam int POS_BYP     = 2;
   localparam int POS_SEL_LO  = 8;
   localparam int POS_RTC_EN  = 15;
   localparam int POS_SWRST   = 16;

   typedef struct packed {
      logic       osc_en;
      logic       osc_byp;
      logic [1:0] rtc_sel;
      logic       rtc_en;
   } bkd_fields_t;

   function automatic logic [DATA_W-1:0] pack_word(bkd_fields_t f, logic rdy, logic sw);
      logic [DATA_W-1:0] w;
      w = '0;
      w[POS_OSC_EN]               = f.osc_en;
      w[POS_RDY]                  = rdy;
      w[POS_BYP]                  = f.osc_byp;
      w[POS_SEL_LO+1:POS_SEL_LO]  = f.rtc_sel;
      w[POS_RTC_EN]               = f.rtc_en;
      w[POS_SWRST]                = sw;
      return w;
   endfunction

endpackage

// File: rtl/bkdom_sync.sv
module bkdom_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bkdom_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bkdom_waitgen.sv
module bkdom_waitgen #(
   parameter int WAIT_STATES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_en,
   output logic acc_ready
);
   localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES + 1) : 1;

   if (WAIT_STATES < 0 || WAIT_STATES > 3) begin : g_bad_wait
      $error("bkdom_waitgen: WAIT_STATES must lie in 0..3");
   end

   if (WAIT_STATES == 0) begin : g_nowait
      assign acc_ready = acc_en;
   end else begin : g_wait
      logic             prev_done_q;
      logic             stalling_q;
      logic [CNT_W-1:0] left_q;

      assign acc_ready = acc_en && (stalling_q ? (left_q == '0) : !prev_done_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_done_q <= 1'b0;
            stalling_q  <= 1'b0;
            left_q      <= '0;
         end else begin
            prev_done_q <= acc_en && acc_ready;
            if (stalling_q) begin
               if (left_q == '0) stalling_q <= 1'b0;
               else              left_q     <= left_q - 1'b1;
            end else if (acc_en && prev_done_q) begin
               stalling_q <= 1'b1;
               left_q     <= CNT_W'(WAIT_STATES - 1);
            end
         end
      end

      // R10: a request in the cycle after a completion is stalled
      p_b2b_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_en && acc_ready) ##1 acc_en |-> !acc_ready);

      // R9: a fresh request after an idle cycle completes at once
      p_fresh_nowait_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_en && !$past(acc_en)) |-> acc_ready);
   end
endmodule

// File: rtl/bkdom_fields.sv
module bkdom_fields
   import bkdom_pkg::*;
(
   input  logic        clk,
   input  logic        bkd_rst_n,
   input  logic        wr_stb,
   input  logic [2:0]  wr_lane,
   input  bkd_fields_t wr_val,
   input  logic        wr_sw,
   input  logic        dom_wr_permit,
   output bkd_fields_t fld_o,
   output logic        sw_o
);
   bkd_fields_t fld_q;
   logic        sw_q;

   always_ff @(posedge clk or negedge bkd_rst_n) begin
      if (!bkd_rst_n) begin
         fld_q <= '0;
         sw_q  <= 1'b0;
      end else begin
         if (wr_stb && wr_lane[2]) sw_q <= wr_sw;
         if (sw_q) begin
            fld_q <= '0;
         end else if (wr_stb && dom_wr_permit) begin
            if (wr_lane[0]) begin
               fld_q.osc_en  <= wr_val.osc_en;
               fld_q.osc_byp <= wr_val.osc_byp;
            end
            if (wr_lane[1]) begin
               fld_q.rtc_sel <= wr_val.rtc_sel;
               fld_q.rtc_en  <= wr_val.rtc_en;
            end
         end
      end
   end

   assign fld_o = fld_q;
   assign sw_o  = sw_q;

   // R4: without write permission the protected fields hold
   p_locked_hold_r4: assert property (@(posedge clk) disable iff (!bkd_rst_n)
      (!dom_wr_permit && !sw_q) |=> $stable(fld_q));

   // R7: software domain reset clears protected fields next cycle
   p_swrst_clear_r7: assert property (@(posedge clk) disable iff (!bkd_rst_n)
      sw_q |=> (fld_q == '0));
endmodule

// File: rtl/bkdom_ctrl_reg.sv
module bkdom_ctrl_reg
   import bkdom_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter logic [7:0]  REG_OFFSET  = 8'h20,
   parameter int          WAIT_STATES = 2,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              sys_rst_n,
   input  logic              bkd_rst_n,
   input  logic              acc_en,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [31:0]       acc_wdata,
   input  logic [3:0]        acc_be,
   output logic              acc_ready,
   output logic [31:0]       acc_rdata,
   input  logic              dom_wr_permit,
   input  logic              osc_rdy_i,
   output logic              osc_en_o,
   output logic              osc_byp_o,
   output logic [1:0]        rtc_sel_o,
   output logic              rtc_en_o,
   output logic              bkd_rst_o
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("bkdom_ctrl_reg: ADDR_W too small for REG_OFFSET");
   end
   if (REG_OFFSET[1:0] != 2'b00) begin : g_bad_align
      $error("bkdom_ctrl_reg: REG_OFFSET must be word aligned");
   end

   logic        hit;
   logic        wr_stb;
   logic        rdy_sync;
   logic        sw_bit;
   bkd_fields_t fld;
   bkd_fields_t wr_val;
   logic        unused_bits;

   assign hit    = (acc_addr == HIT_ADDR);
   assign wr_stb = acc_en && acc_ready && acc_write && hit;

   assign wr_val.osc_en  = acc_wdata[POS_OSC_EN];
   assign wr_val.osc_byp = acc_wdata[POS_BYP];
   assign wr_val.rtc_sel = acc_wdata[POS_SEL_LO+1:POS_SEL_LO];
   assign wr_val.rtc_en  = acc_wdata[POS_RTC_EN];
   assign unused_bits    = ^{acc_wdata[31:17], acc_wdata[14:10], acc_wdata[7:3],
                             acc_wdata[1], acc_be[3]};

   bkdom_waitgen #(.WAIT_STATES(WAIT_STATES)) u_wait (
      .clk       (clk),
      .rst_n     (sys_rst_n),
      .acc_en    (acc_en),
      .acc_ready (acc_ready)
   );

   bkdom_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .d_i   (osc_rdy_i),
      .q_o   (rdy_sync)
   );

   bkdom_fields u_fields (
      .clk           (clk),
      .bkd_rst_n     (bkd_rst_n),
      .wr_stb        (wr_stb),
      .wr_lane       (acc_be[2:0]),
      .wr_val        (wr_val),
      .wr_sw         (acc_wdata[POS_SWRST]),
      .dom_wr_permit (dom_wr_permit),
      .fld_o         (fld),
      .sw_o          (sw_bit)
   );

   assign acc_rdata = (acc_en && !acc_write && hit) ? pack_word(fld, rdy_sync, sw_bit) : '0;

   assign osc_en_o  = fld.osc_en;
   assign osc_byp_o = fld.osc_byp;
   assign rtc_sel_o = fld.rtc_sel;
   assign rtc_en_o  = fld.rtc_en;
   assign bkd_rst_o = sw_bit || !bkd_rst_n;
endmodule

// File: tb/bkdom_ctrl_reg_tb.sv
module bkdom_ctrl_reg_tb;
   localparam int WS = 2;
   localparam logic [7:0] OFS = 8'h20;

   logic        clk = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic        bkd_rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_write = 1'b0;
   logic [7:0]  acc_addr = 8'h00;
   logic [31:0] acc_wdata = '0;
   logic [3:0]  acc_be = 4'h0;
   logic        dom_wr_permit = 1'b0;
   logic        osc_rdy_i = 1'b0;
   logic        acc_ready;
   logic [31:0] acc_rdata;
   logic        osc_en_o, osc_byp_o, rtc_en_o, bkd_rst_o;
   logic [1:0]  rtc_sel_o;

   bkdom_ctrl_reg u_dut (
      .clk(clk), .sys_rst_n(sys_rst_n), .bkd_rst_n(bkd_rst_n),
      .acc_en(acc_en), .acc_write(acc_write), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_be(acc_be), .acc_ready(acc_ready),
      .acc_rdata(acc_rdata), .dom_wr_permit(dom_wr_permit), .osc_rdy_i(osc_rdy_i),
      .osc_en_o(osc_en_o), .osc_byp_o(osc_byp_o), .rtc_sel_o(rtc_sel_o),
      .rtc_en_o(rtc_en_o), .bkd_rst_o(bkd_rst_o)
   );

   always #10 clk = ~clk;

   // reference model state
   int    n_cmp = 0, n_bad = 0, cyc = 0;
   string phase = "R1 reset";
   bit    m_en = 0, m_byp = 0, m_rtc = 0, m_sw = 0;
   bit [1:0] m_sel = 0;
   bit    s1 = 0, s2 = 0, m_prev = 0, m_stall = 0, done_n = 0;
   int    m_left = 0;

   function automatic bit [31:0] model_word();
      bit [31:0] w = '0;
      w[0] = m_en; w[1] = s2; w[2] = m_byp; w[9:8] = m_sel; w[15] = m_rtc; w[16] = m_sw;
      return w;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
      end
   endtask

   // bus-side model: synchroniser and wait-state timing (R8, R9, R10)
   always @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         s1 = 0; s2 = 0; m_prev = 0; m_stall = 0; m_left = 0;
      end else begin
         s2 = s1; s1 = osc_rdy_i;
         if (m_stall) begin
            if (m_left == 0) m_stall = 0; else m_left--;
         end else if (acc_en && m_prev) begin
            m_stall = 1; m_left = WS - 1;
         end
         m_prev = done_n;
      end
   end

   // domain-side model (R2, R4, R6, R7, R11, R12)
   always @(posedge clk or negedge bkd_rst_n) begin
      if (!bkd_rst_n) begin
         m_en = 0; m_byp = 0; m_sel = 0; m_rtc = 0; m_sw = 0;
      end else begin
         bit wr, nsw;
         wr  = done_n && acc_write && (acc_addr == OFS);
         nsw = m_sw;
         if (wr && acc_be[2]) nsw = acc_wdata[16];
         if (m_sw) begin
            m_en = 0; m_byp = 0; m_sel = 0; m_rtc = 0;
         end else if (wr && dom_wr_permit) begin
            if (acc_be[0]) begin m_en = acc_wdata[0]; m_byp = acc_wdata[2]; end
            if (acc_be[1]) begin m_sel = acc_wdata[9:8]; m_rtc = acc_wdata[15]; end
         end
         m_sw = nsw;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      bit exp_rdy;
      exp_rdy = acc_en && (m_stall ? (m_left == 0) : !m_prev);
      chk("R9/R10 ready", 32'(acc_ready), 32'(exp_rdy));
      if (exp_rdy && !acc_write)
         chk("R2/R3/R8/R12 rdata", acc_rdata, (acc_addr == OFS) ? model_word() : 32'h0);
      chk("R1/R2/R4/R5/R7/R11 fields", {27'b0, osc_en_o, osc_byp_o, rtc_sel_o, rtc_en_o},
          {27'b0, m_en, m_byp, m_sel, m_rtc});
      chk("R6 domain reset", 32'(bkd_rst_o), 32'(m_sw || !bkd_rst_n));
      done_n = exp_rdy;
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog expired [%s] actual=hung expected=done", phase);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] b, input bit keep);
      acc_en = 1; acc_write = wr; acc_addr = a; acc_wdata = d; acc_be = b;
      do @(negedge clk); while (!acc_ready);
      @(posedge clk); #2;
      if (!keep) acc_en = 0;
   endtask

   task automatic idle(input int n);
      acc_en = 0;
      repeat (n) begin @(posedge clk); #2; end
   endtask

   initial begin
      // R1: both resets held, then released; reads return zero
      repeat (3) @(posedge clk);
      #2; sys_rst_n = 1; bkd_rst_n = 1;
      idle(2);
      acc(0, OFS, 0, 4'h0, 0);
      // R4: writes refused while permission is low
      phase = "R4 locked write";
      acc(1, OFS, 32'h0000_FFFF, 4'hF, 0); idle(1);
      acc(0, OFS, 0, 4'h0, 0);
      // R2: full write with permission, read back
      phase = "R2 layout";
      dom_wr_permit = 1;
      acc(1, OFS, 32'h0000_8305, 4'hF, 0); idle(1);
      acc(0, OFS, 0, 4'h0, 0); idle(1);
      // R3: reserved ones ignored, bit 16 kept clear
      phase = "R3 reserved";
      acc(1, OFS, 32'hFFFE_7CF8, 4'hF, 0); idle(1);
      acc(0, OFS, 0, 4'h0, 0); idle(1);
      // R11: lane 1 only, then lane 0 only
      phase = "R11 lanes";
      acc(1, OFS, 32'h0000_8301, 4'h2, 0); idle(1);
      acc(1, OFS, 32'h0000_0004, 4'h1, 0); idle(1);
      acc(0, OFS, 0, 4'h0, 0); idle(1);
      // R5: system reset keeps domain fields
      phase = "R5 sys reset";
      sys_rst_n = 0; idle(2); sys_rst_n = 1; idle(1);
      acc(0, OFS, 0, 4'h0, 0); idle(1);
      // R6/R7: software reset via lane 2 while locked, writes ignored while set
      phase = "R6 R7 swrst";
      dom_wr_permit = 0;
      acc(1, OFS, 32'h0001_0000, 4'h4, 0); idle(2);
      dom_wr_permit = 1;
      acc(1, OFS, 32'h0001_8305, 4'h3, 0); idle(1);
      acc(0, OFS, 0, 4'h0, 0); idle(1);
      acc(1, OFS, 32'h0000_0000, 4'h4, 0); idle(2);
      acc(1, OFS, 32'h0000_0201, 4'h3, 0); idle(1);
      // R8: oscillator status through the synchroniser
      phase = "R8 ready flag";
      osc_rdy_i = 1; idle(1);
      acc(0, OFS, 0, 4'h0, 0);
      acc(0, OFS, 0, 4'h0, 0); idle(3);
      osc_rdy_i = 0;
      acc(0, OFS, 0, 4'h0, 0); idle(2);
      acc(1, OFS, 32'h0000_0002, 4'h1, 0); idle(1);
      // R9/R10: single accesses and back-to-back chains
      phase = "R9 R10 wait states";
      acc(0, OFS, 0, 4'h0, 1);
      acc(0, OFS, 0, 4'h0, 1);
      acc(1, OFS, 32'h0000_0105, 4'h3, 1);
      acc(0, OFS, 0, 4'h0, 0); idle(1);
      acc(1, OFS, 32'h0000_8001, 4'h3, 0); idle(2);
      // R12: other addresses
      phase = "R12 decode";
      acc(1, 8'h24, 32'h0001_0000, 4'hF, 0); idle(1);
      acc(1, 8'h00, 32'h0000_0000, 4'hF, 0); idle(1);
      acc(0, 8'h24, 0, 4'h0, 0); idle(1);
      acc(0, OFS, 0, 4'h0, 0); idle(1);
      // R1/R6: external domain reset clears everything
      phase = "R1 R6 domain reset";
      bkd_rst_n = 0; idle(2); bkd_rst_n = 1; idle(1);
      acc(0, OFS, 0, 4'h0, 0); idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule